// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Divider

This block derives the SPI serial clock from the system clock. A prescaler divides the system clock first. A period counter then divides the prescaler ticks again and steps the clock through an active phase and an idle phase. The outputs are the serial clock and two single-cycle strobes, one for each clock edge, which a shift engine uses to launch and capture data. The divider settings come as one 32-bit configuration word. The prescaler sits in the low half-word. The period count sits in the high half-word. Each value is clamped to its supported range and stored as the value minus one.

When the count is one or less, the block uses a bypass path. The system clock itself then goes out as the serial clock, inverted when the idle level is high. The configuration and the idle level are captured only while the run enable is low. While the run enable is low, the serial clock rests at the idle level and both counters stay cleared. Readback outputs show the stored fields, so the effective rate is the system clock divided by (prescaler field + 1) and by (count field + 1).

Top module: `spi_clk_div`

## Requirements
- R1: The prescaler is taken from cfgDiv[15:0] and the period count from cfgDiv[31:16]. While idle and not in bypass, effPre reads back prescaler − 1 and effCount reads back count − 1.
- R2: A prescaler above 8192 is clamped to 8192. A prescaler of 0 is treated as 1. A count above 64 is clamped to 64.
- R3: A count of 0 or 1 selects bypass. In bypass, bypassMode is 1 and effPre and effCount both read 0. While running, sck equals clk XOR the captured idle level, and leadEdge and trailEdge are both 1 on every cycle from the first clock edge after the run enable onward.
- R4: Outside bypass, the serial clock period is exactly prescaler × count system clock cycles.
- R5: Let h = floor(count/2), and count n from 1 at the first rising edge after run enable goes high. sck goes active (the opposite of the idle level) after edge n where n mod (prescaler × count) equals prescaler × h. It returns to the idle level where n mod (prescaler × count) equals 0.
- R6: leadEdge is high for exactly the one cycle in which sck has just become active. trailEdge is high for exactly the one cycle in which sck has just returned to idle.
- R7: While runEn is low, sck equals the cpol input delayed by one clock, both strobes are 0, and both counters restart from zero on the next run.
- R8: Changes to cfgDiv or cpol while runEn is high have no effect on sck, the strobes or the readback until the block is idle again.
- R9: The readback gives the requested rate. With an 80 MHz system clock, a prescaler of 8 with count 10 reads back as 1 MHz, and a prescaler of 1 with count 2 reads back as 40 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgDiv | input | 32 | Packed divider: prescaler in [15:0], count in [31:16] |
| cpol | input | 1 | Idle level of the serial clock |
| runEn | input | 1 | Run enable; low holds the block idle and loads the settings |
| sck | output | 1 | Serial clock |
| leadEdge | output | 1 | One-cycle strobe on the idle-to-active transition |
| trailEdge | output | 1 | One-cycle strobe on the active-to-idle transition |
| effPre | output | 13 | Stored prescaler minus one |
| effCount | output | 6 | Stored count minus one |
| bypassMode | output | 1 | High when the bypass path is selected |

## Verification
A prescaler counter that wraps at the wrong value shows up at the ports within one prescaler interval. The first leadEdge then arrives at the wrong cycle, and every later edge drifts further. A wrong high point or wrap point in the period counter moves the sck transitions inside the first period, so the duty ratio or the period length is off by whole prescaler intervals. A wrong clamp or a wrong bypass decision appears on the readback and on bypassMode one cycle after the configuration is applied, before any run starts.

// File: rtl/spi_clk_pkg.sv
package spi_clk_pkg;
  typedef struct packed {
    logic run;
    logic bypass;
    logic idleLvl;
    logic setHigh;
    logic setLow;
  } clk_strobe_t;
endpackage

// File: rtl/spi_clk_ctrl.sv
module spi_clk_ctrl
  import spi_clk_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfgDiv,
  input  logic             cpol,
  input  logic             runEn,
  output clk_strobe_t      st,
  output logic [PRE_W-1:0] effPre,
  output logic [CNT_W-1:0] effCount,
  output logic             bypassOut
);
  localparam int PRE_MAX = 1 << PRE_W;
  localparam int CNT_MAX = 1 << CNT_W;

  logic [15:0] preRaw, cntRaw;
  logic [16:0] preClamp, cntClamp;
  logic [PRE_W-1:0] preM1Next, preM1R, preCnt;
  logic [CNT_W-1:0] cntM1Next, highNext, cntM1R, highR, perCnt;
  logic bypNext, bypR, cpolR, tick;

  assign preRaw = cfgDiv[15:0];
  assign cntRaw = cfgDiv[31:16];

  always_comb begin
    if (preRaw == 16'd0)                    preClamp = 17'd1;
    else if ({1'b0, preRaw} > 17'(PRE_MAX)) preClamp = 17'(PRE_MAX);
    else                                    preClamp = {1'b0, preRaw};
    if ({1'b0, cntRaw} > 17'(CNT_MAX))      cntClamp = 17'(CNT_MAX);
    else                                    cntClamp = {1'b0, cntRaw};
    bypNext   = (cntRaw <= 16'd1);
    preM1Next = bypNext ? '0 : PRE_W'(preClamp - 17'd1);
    cntM1Next = bypNext ? '0 : CNT_W'(cntClamp - 17'd1);
    highNext  = bypNext ? '0 : CNT_W'((cntClamp >> 1) - 17'd1);
  end

  assign tick = runEn && !bypR && (preCnt == preM1R);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preM1R <= '0; cntM1R <= '0; highR <= '0; bypR <= 1'b1; cpolR <= 1'b0;
      preCnt <= '0; perCnt <= '0;
    end else if (!runEn) begin
      preM1R <= preM1Next; cntM1R <= cntM1Next; highR <= highNext;
      bypR <= bypNext; cpolR <= cpol;
      preCnt <= '0; perCnt <= '0;
    end else if (!bypR) begin
      if (tick) begin
        preCnt <= '0;
        perCnt <= (perCnt == cntM1R) ? '0 : perCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign st.run     = runEn;
  assign st.bypass  = bypR;
  assign st.idleLvl = cpolR;
  assign st.setHigh = tick && (perCnt == highR);
  assign st.setLow  = tick && (perCnt == cntM1R);

  assign effPre    = preM1R;
  assign effCount  = cntM1R;
  assign bypassOut = bypR;

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= preM1R); // R4
  AST_PER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    perCnt <= cntM1R); // R4
  AST_HIGH_BEFORE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && !bypR) |-> (highR < cntM1R)); // R5
  AST_NO_DUAL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.setHigh && st.setLow)); // R6
endmodule

// File: rtl/spi_clk_dp.sv
module spi_clk_dp
  import spi_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpol,
  input  clk_strobe_t st,
  output logic        sck,
  output logic        leadEdge,
  output logic        trailEdge
);
  logic sckReg, leadR, trailR;

  always_ff @(posedge clk) begin
    if (!rst_n || !st.run) begin
      sckReg <= cpol;
      leadR  <= 1'b0;
      trailR <= 1'b0;
    end else if (st.bypass) begin
      sckReg <= st.idleLvl;
      leadR  <= 1'b1;
      trailR <= 1'b1;
    end else begin
      leadR  <= st.setHigh;
      trailR <= st.setLow;
      if (st.setHigh)     sckReg <= ~st.idleLvl;
      else if (st.setLow) sckReg <= st.idleLvl;
    end
  end

  assign sck       = (st.run && st.bypass) ? (clk ^ st.idleLvl) : sckReg;
  assign leadEdge  = leadR;
  assign trailEdge = trailR;

  AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (leadR && !st.bypass) |=> !leadR); // R6
  AST_LEAD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (leadR && !st.bypass && st.run) |-> (sckReg != st.idleLvl)); // R6
  AST_TRAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trailR && !st.bypass && st.run) |-> (sckReg == st.idleLvl)); // R6
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.run && $past(!st.run)) |-> (sckReg == $past(cpol))); // R7
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfgDiv,
  input  logic             cpol,
  input  logic             runEn,
  output logic             sck,
  output logic             leadEdge,
  output logic             trailEdge,
  output logic [PRE_W-1:0] effPre,
  output logic [CNT_W-1:0] effCount,
  output logic             bypassMode
);
  clk_strobe_t strobes;

  spi_clk_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgDiv(cfgDiv), .cpol(cpol), .runEn(runEn),
    .st(strobes), .effPre(effPre), .effCount(effCount), .bypassOut(bypassMode)
  );

  spi_clk_dp u_dp (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .st(strobes),
    .sck(sck), .leadEdge(leadEdge), .trailEdge(trailEdge)
  );
endmodule

// File: tb/tb_spi_clk_div.sv
`timescale 1ns/1ps
module tb_spi_clk_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfgDiv = '0;
  logic cpol = 1'b0;
  logic runEn = 1'b0;
  logic sck, leadEdge, trailEdge, bypassMode;
  logic [12:0] effPre;
  logic [5:0] effCount;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_clk_div dut (
    .clk(clk), .rst_n(rst_n), .cfgDiv(cfgDiv), .cpol(cpol), .runEn(runEn),
    .sck(sck), .leadEdge(leadEdge), .trailEdge(trailEdge),
    .effPre(effPre), .effCount(effCount), .bypassMode(bypassMode)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic runCase(input int pre, input int cnt, input bit pol,
                         input int periods, input bit midChange);
    int pe, ce, h, per, ph;
    bit byp, expS;
    pe  = (pre == 0) ? 1 : ((pre > 8192) ? 8192 : pre);
    ce  = (cnt > 64) ? 64 : cnt;
    byp = (cnt <= 1);
    @(negedge clk);
    runEn = 1'b0; cfgDiv = {cnt[15:0], pre[15:0]}; cpol = pol;
    repeat (3) @(negedge clk);
    chk(sck == pol, "R7 idle sck", sck, pol);
    chk(!leadEdge && !trailEdge, "R7 idle strobes", {leadEdge, trailEdge}, 0);
    chk(bypassMode == byp, "R3 bypass flag", bypassMode, byp);
    chk(effPre == (byp ? 0 : pe - 1), "R1/R2 effPre", effPre, byp ? 0 : pe - 1);
    chk(effCount == (byp ? 0 : ce - 1), "R1/R2 effCount", effCount, byp ? 0 : ce - 1);
    if (periods == 0) return;
    if (byp) begin
      runEn = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        chk(sck == pol, "R3 bypass sck low phase", sck, pol);
        chk(leadEdge && trailEdge, "R3 bypass strobes", {leadEdge, trailEdge}, 3);
        @(posedge clk); #1;
        chk(sck == !pol, "R3 bypass sck high phase", sck, !pol);
        @(negedge clk);
      end
      runEn = 1'b0;
      return;
    end
    h = ce / 2; per = pe * ce;
    runEn = 1'b1;
    for (int n = 1; n <= periods * per; n++) begin
      @(posedge clk); @(negedge clk);
      ph = n % per;
      expS = (ph >= pe * h) ? !pol : pol;
      chk(sck == expS, "R4/R5 sck level", sck, expS);
      chk(leadEdge == (ph == pe * h), "R6 leadEdge", leadEdge, ph == pe * h);
      chk(trailEdge == (ph == 0), "R6 trailEdge", trailEdge, ph == 0);
      if (midChange && n == per / 2) begin
        cfgDiv = 32'h0003_0005;
        cpol = !pol;
      end
    end
    if (midChange) begin
      chk(effCount == ce - 1, "R8 readback held", effCount, ce - 1);
      chk(effPre == pe - 1, "R8 readback held", effPre, pe - 1);
    end
    runEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f;
    repeat (3) @(negedge clk);
    chk(sck == 1'b0 && !leadEdge && !trailEdge, "R7 reset state", sck, 0);
    rst_n = 1'b1;
    // near-exhaustive sweep of small settings
    for (int p = 1; p <= 4; p++)
      for (int c = 2; c <= 8; c++)
        for (int pl = 0; pl < 2; pl++)
          runCase(p, c, pl[0], 2, 1'b0);
    runCase(8, 10, 1'b0, 2, 1'b0);
    runCase(1, 2, 1'b1, 3, 1'b0);
    runCase(0, 4, 1'b0, 2, 1'b0);        // R2 prescaler zero treated as one
    runCase(1, 100, 1'b0, 1, 1'b0);      // R2 count clamp to 64
    runCase(9000, 100, 1'b0, 0, 1'b0);   // R2 prescaler clamp to 8192
    runCase(8192, 64, 1'b1, 0, 1'b0);    // R1 upper limits
    runCase(7, 0, 1'b0, 1, 1'b0);        // R3
    runCase(3, 1, 1'b1, 1, 1'b0);        // R3
    runCase(1, 1, 1'b0, 1, 1'b0);        // R3
    runCase(3, 5, 1'b0, 3, 1'b1);        // R8
    runCase(2, 7, 1'b1, 2, 1'b1);        // R8
    // R9 frequency identity
    @(negedge clk); runEn = 1'b0; cfgDiv = {16'd10, 16'd8};
    repeat (2) @(negedge clk);
    f = 80000000 / (effPre + 1) / (effCount + 1);
    chk(f == 1000000, "R9 1MHz", f, 1000000);
    cfgDiv = {16'd2, 16'd1};
    repeat (2) @(negedge clk);
    f = 80000000 / (effPre + 1) / (effCount + 1);
    chk(f == 40000000, "R9 40MHz", f, 40000000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule